// File: doc/BRIEF.md
# Multi-Output Priority Encoder

This block reads a request vector and reports where its lowest several set bits sit, all at once. There are `SLOTS` output slots. Slot 0 gives the position of the lowest set bit, slot 1 the position of the next set bit above it, and so on up through the vector. Each slot has a valid flag that shows whether the vector holds enough set bits to fill that slot.

The block has no clock and no state, and it has no handshake. Its outputs follow the request vector within the same evaluation, so it can sit inside a single pipeline stage of a wider datapath. A typical use is picking several free entries from an occupancy mask in one cycle.

Top module: `multi_prio_enc`

## Requirements
- R1: When slot k is valid, its index equals the bit position of the (k+1)-th set bit of `req_i`, counting upward from bit 0.
- R2: Among the valid slots, the indices rise strictly with the slot number.
- R3: Slot k is valid exactly when `req_i` has at least k+1 set bits.
- R4: The index of a slot that is not valid is driven to 0.
- R5: When `req_i` is all zeros, every valid flag is 0.
- R6: The valid flags form a thermometer from slot 0: if slot k+1 is valid, then slot k is valid as well.
- R7: Each index field is max(1, ceil(log2(REQ_W))) bits wide. With REQ_W = 1, slot 0 is valid exactly when bit 0 is set, and its index is 0.
- R8: When `req_i` holds more than SLOTS set bits, only the lowest SLOTS of them are reported, and the set bits above them leave every output unchanged.
- R9: The outputs depend on the current value of `req_i` alone, with no clock or stored state, so each new request is reflected within the cycle in which it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_i | input | REQ_W | Request vector to scan, from the LSB upward |
| slot_idx_o | output | SLOTS*IDX_W | Packed slot indices; slot k occupies bits [k*IDX_W +: IDX_W] |
| slot_vld_o | output | SLOTS | Per-slot valid flags; bit k belongs to slot k |

## Verification
Whenever the inputs change, the bound checker checks these rules: the set-bit count against the valid flags, the thermometer shape of the flags, that each valid index points at a set request bit, that the indices rise from slot to slot, and that the index of each invalid slot is zero. Those rules alone would still accept a design that skips a set bit. Only the bench's scoreboard compares each slot with the exact expected position. It applies patterns that hold more set bits than there are slots, patterns with single bits at both ends of the vector, and dense and sparse mixes. A second instance with a 1-bit request vector covers the narrowest width.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mpe_lowest_set.sv
// Isolates the lowest set bit of a vector and encodes its position.
module mpe_lowest_set #(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic [W-1:0]  vec_i,
  output logic          hit_o,
  output logic [W-1:0]  onehot_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    onehot_o = vec_i & (~vec_i + W'(1));
    hit_o    = |vec_i;
    idx_o    = '0;
    for (int i = 0; i < W; i++) begin
      if (onehot_o[i]) idx_o = idx_o | IW'(i);
    end
  end
endmodule

// File: rtl/mpe_stage.sv
// One cascade stage: report the lowest set bit and clear it for the next stage.
module mpe_stage #(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic [W-1:0]  vec_i,
  output logic [W-1:0]  rest_o,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);
  logic [W-1:0] pick;

  mpe_lowest_set #(.W(W), .IW(IW)) find_i (
    .vec_i   (vec_i),
    .hit_o   (vld_o),
    .onehot_o(pick),
    .idx_o   (idx_o)
  );

  assign rest_o = vec_i & ~pick;
endmodule

// File: rtl/multi_prio_enc.sv
module multi_prio_enc #(
  parameter int REQ_W = 24,
  parameter int SLOTS = 4,
  localparam int IDX_W = mpe_pkg::idx_width(REQ_W)
) (
  input  logic [REQ_W-1:0]       req_i,
  output logic [SLOTS*IDX_W-1:0] slot_idx_o,
  output logic [SLOTS-1:0]       slot_vld_o
);
  logic [REQ_W-1:0] chain [SLOTS];
  logic [REQ_W-1:0] residue_unused;

  assign chain[0] = req_i;

  for (genvar k = 0; k < SLOTS; k++) begin : g_stage
    logic [REQ_W-1:0] nxt;

    mpe_stage #(.W(REQ_W), .IW(IDX_W)) stage_i (
      .vec_i (chain[k]),
      .rest_o(nxt),
      .vld_o (slot_vld_o[k]),
      .idx_o (slot_idx_o[k*IDX_W +: IDX_W])
    );

    if (k == SLOTS - 1) begin : g_last
      assign residue_unused = nxt;
    end else begin : g_pass
      assign chain[k+1] = nxt;
    end
  end
endmodule

// File: rtl/mpe_checker.sv
module mpe_checker #(
  parameter int REQ_W = 24,
  parameter int SLOTS = 4,
  localparam int IDX_W = mpe_pkg::idx_width(REQ_W)
) (
  input logic [REQ_W-1:0]       req_i,
  input logic [SLOTS*IDX_W-1:0] slot_idx_o,
  input logic [SLOTS-1:0]       slot_vld_o
);
  always_comb begin
    // R5
    if (req_i == '0) begin
      assert_zero_idle_R5: assert (slot_vld_o == '0);
    end
    for (int k = 0; k < SLOTS; k++) begin
      assert_count_valid_R3: assert (slot_vld_o[k] == ($countones(req_i) > k));
      if (!slot_vld_o[k]) begin
        assert_invalid_zero_R4: assert (slot_idx_o[k*IDX_W +: IDX_W] == '0);
      end else begin
        assert_points_at_set_R1: assert (int'(slot_idx_o[k*IDX_W +: IDX_W]) < REQ_W
                                         && req_i[slot_idx_o[k*IDX_W +: IDX_W]]);
      end
      if (k > 0) begin
        assert_thermometer_R6: assert (!slot_vld_o[k] || slot_vld_o[k-1]);
        if (slot_vld_o[k]) begin
          assert_ascending_R2: assert (slot_idx_o[k*IDX_W +: IDX_W]
                                       > slot_idx_o[(k-1)*IDX_W +: IDX_W]);
        end
      end
    end
  end
endmodule

bind multi_prio_enc mpe_checker #(.REQ_W(REQ_W), .SLOTS(SLOTS)) chk_i (
  .req_i     (req_i),
  .slot_idx_o(slot_idx_o),
  .slot_vld_o(slot_vld_o)
);

// File: tb/multi_prio_enc_tb_top.sv
module multi_prio_enc_tb_top;
  localparam int N  = 24;
  localparam int M  = 4;
  localparam int IW = mpe_pkg::idx_width(N);

  typedef struct {
    logic [N-1:0]    req;
    logic [M*IW-1:0] exp_idx;
    logic [M-1:0]    exp_vld;
    string           tag;
  } item_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [N-1:0]    req = '0;
  logic [M*IW-1:0] idx;
  logic [M-1:0]    vld;
  logic            req1 = 1'b0;
  logic [1:0]      idx1;
  logic [1:0]      vld1;

  int applied = 0;
  int miscomp = 0;
  bit drv_done = 0;
  item_t sb[$];

  multi_prio_enc #(.REQ_W(N), .SLOTS(M)) dut_i (
    .req_i(req), .slot_idx_o(idx), .slot_vld_o(vld));

  // R7: 1-bit request, two slots, 1-bit index fields
  multi_prio_enc #(.REQ_W(1), .SLOTS(2)) dut_one_i (
    .req_i(req1), .slot_idx_o(idx1), .slot_vld_o(vld1));

  task automatic model(input logic [N-1:0] r, output logic [M*IW-1:0] ix,
                       output logic [M-1:0] v);
    int cnt = 0;
    ix = '0;
    v  = '0;
    for (int b = 0; b < N; b++) begin
      if (r[b] && cnt < M) begin
        ix[cnt*IW +: IW] = IW'(b);
        v[cnt] = 1'b1;
        cnt++;
      end
    end
  endtask

  task automatic drive(input logic [N-1:0] r, input string tag);
    item_t it;
    @(negedge clk);
    req = r;
    it.req = r;
    it.tag = tag;
    model(r, it.exp_idx, it.exp_vld);
    sb.push_back(it);
  endtask

  // monitor: outputs have settled by the next rising edge
  initial begin
    forever begin
      @(posedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        applied++;
        if (idx !== it.exp_idx || vld !== it.exp_vld) begin
          miscomp++;
          $display("FAIL %s req=%h idx=%h vld=%b expected idx=%h vld=%b",
                   it.tag, it.req, idx, vld, it.exp_idx, it.exp_vld);
        end
      end
    end
  end

  task automatic check_one(input logic r, input logic [1:0] ei, input logic [1:0] ev);
    @(negedge clk);
    req1 = r;
    @(posedge clk);
    applied++;
    if (idx1 !== ei || vld1 !== ev) begin
      miscomp++;
      $display("FAIL R7 req=%b idx=%b vld=%b expected idx=%b vld=%b",
               r, idx1, vld1, ei, ev);
    end
  endtask

  initial begin
    logic [N-1:0] lfsr = 24'hACE1F3;
    drive('0, "R5");
    drive(24'h000001, "R1");
    drive(24'h800000, "R1");
    drive(24'h800001, "R2");
    drive(24'h000F00, "R3");
    drive(24'h000007, "R3");
    drive(24'h0000FF, "R8");
    drive(24'hFFFFFF, "R8");
    drive(24'hF0000F, "R8");
    drive(24'h101010, "R6");
    drive(24'h400000, "R4");
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
      drive(lfsr & (i[0] ? 24'h842108 : 24'hFFFFFF), "R9");
    end
    for (int s = 0; s < N; s++) drive(N'(1) << s, "R1");
    repeat (3) @(posedge clk);
    check_one(1'b0, 2'b00, 2'b00);
    check_one(1'b1, 2'b00, 2'b01);
    check_one(1'b0, 2'b00, 2'b00);
    drv_done = 1;
  end

  initial begin
    fork
      wait (drv_done);
      begin
        repeat (100000) @(posedge clk);
        miscomp++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
    $finish;
  end
endmodule